// File: doc/BRIEF.md
# Prefix-Extended Halfword Store Unit

This block handles the halfword store operation of a processor with sixteen 32-bit general registers and a 16-bit instruction word. It watches the instruction stream one word per cycle. It reads two registers through a combinational register-file read port: a base register and a source register. When it sees the store opcode, it writes the low 16 bits of the source register to memory at an effective address derived from the base register.

Immediate-extension prefix words may come just before the store. They switch the addressing mode from plain register indirect to register indirect with a displacement. One prefix gives a 13-bit displacement. Two back-to-back prefixes join into a 26-bit displacement. The displacement is zero-extended before the add. Prefix state applies only to the next non-prefix instruction and is cleared once that instruction is consumed.

A store without prefixes writes one cycle after it is accepted. A store with prefixes takes an extra cycle for the address add. During that cycle the unit holds its ready output low. An odd effective address suppresses the write and raises a one-cycle misalignment exception instead.

Top module: `hs_store_unit`

## Requirements
- R1: A word with bits 15:8 equal to 0x38 is a store, with the base register index in bits 7:4 and the source register index in bits 3:0. Any other word whose bits 15:13 are not 110 produces no memory write and no exception.
- R2: A store writes bits 15:0 of the source register as write data. The byte enables are 4'b0011 when effective address bit 1 is 0, and 4'b1100 when it is 1.
- R3: With no pending prefix, the effective address is the base register value. Write enable rises in the cycle after the store is accepted, and ready stays high.
- R4: A prefix word has bits 15:13 equal to 110 and carries a 13-bit immediate in bits 12:0. After one prefix, the effective address is base plus the zero-extended immediate, modulo 2^32.
- R5: After two consecutive prefixes, the displacement is the first immediate shifted left by 13 bits, ORed with the second immediate.
- R6: After three or more consecutive prefixes, only the two most recent immediates form the displacement, in the R5 arrangement.
- R7: A store accepted with a pending prefix drives ready low for exactly one cycle after acceptance, with no write in that cycle. It produces its write two cycles after acceptance.
- R8: Prefix state is cleared when any non-prefix word is accepted, store or not. A store that follows a prefix and an intervening non-prefix word uses the plain base address.
- R9: When the effective address is odd, no write occurs. Instead, the misalignment exception is high for one cycle, in the cycle the write would have occurred, with the effective address on the address output.
- R10: During and right after reset, write enable and the exception are low, ready is high, and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| instr_ready | output | 1 | Unit can accept a word this cycle |
| rf_raddr_base | output | 4 | Register index of the base (instr bits 7:4) |
| rf_raddr_src | output | 4 | Register index of the source (instr bits 3:0) |
| rf_rdata_base | input | 32 | Base register value |
| rf_rdata_src | input | 32 | Source register value |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 16 | Halfword write data |
| mem_be | output | 4 | Byte-lane enables |
| misalign_exc | output | 1 | Address-misaligned exception pulse |

## Verification
The bench joins prefixes with immediates that would land in the wrong bits if the two fields were swapped or left unshifted. A run of three prefixes catches an accumulator that keeps the oldest field instead of the newest. It places a non-store word between a prefix and a store; a unit that failed to clear the prefix would add a stale displacement there. Odd addresses are produced both directly and through a displacement, which exposes a unit that still writes or that holds the exception past one cycle. The one-cycle stall is checked cycle by cycle so that a write appearing a cycle early or late is flagged.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int INSTR_W   = 16;
    localparam int REG_AW    = 4;
    localparam int IMM_W     = 13;
    localparam int HALF_W    = 16;

    localparam logic [7:0] STORE_OPC  = 8'h38;
    localparam logic [2:0] PREFIX_TAG = 3'b110;

    typedef struct packed {
        logic              is_store;
        logic              is_prefix;
        logic [REG_AW-1:0] base_idx;
        logic [REG_AW-1:0] src_idx;
        logic [IMM_W-1:0]  imm;
    } hs_dec_t;

endpackage

// File: rtl/hs_decode.sv
module hs_decode
    import hs_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output hs_dec_t            dec_o
);

    always_comb begin
        dec_o           = '0;
        dec_o.is_store  = (word_i[15:8] == STORE_OPC);
        dec_o.is_prefix = (word_i[15:13] == PREFIX_TAG);
        dec_o.base_idx  = word_i[7:4];
        dec_o.src_idx   = word_i[3:0];
        dec_o.imm       = word_i[IMM_W-1:0];
    end

endmodule

// File: rtl/hs_prefix_acc.sv
module hs_prefix_acc
    import hs_pkg::*;
#(
    parameter int NPFX = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take_i,
    input  logic                    is_prefix_i,
    input  logic [IMM_W-1:0]        imm_i,
    output logic [IMM_W*NPFX-1:0]   disp_o,
    output logic                    active_o
);

    localparam int DISP_W = IMM_W * NPFX;
    localparam int CNT_W  = $clog2(NPFX + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NPFX);

    typedef struct packed {
        logic [DISP_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [DISP_W-1:0] shifted;

    generate
        if (NPFX == 1) begin : g_single
            assign shifted = imm_i;
        end else begin : g_multi
            assign shifted = {acc_q.acc[DISP_W-IMM_W-1:0], imm_i};
        end
    endgenerate

    always_comb begin
        acc_d = acc_q;
        if (take_i) begin
            if (is_prefix_i) begin
                acc_d.acc = shifted;
                acc_d.cnt = (acc_q.cnt == CNT_MAX) ? CNT_MAX : acc_q.cnt + 1'b1;
            end else begin
                acc_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign disp_o   = acc_q.acc;
    assign active_o = (acc_q.cnt != '0);

endmodule

// File: rtl/hs_lane_sel.sv
module hs_lane_sel #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   ea_i,
    output logic [XLEN/8-1:0] be_o,
    output logic              odd_o
);

    localparam int BE_W    = XLEN / 8;
    localparam int NHALF   = BE_W / 2;
    localparam int LANE_AW = $clog2(BE_W);

    logic [LANE_AW-1:0] byte_off;
    assign byte_off = ea_i[LANE_AW-1:0];
    assign odd_o    = ea_i[0];

    generate
        for (genvar h = 0; h < NHALF; h++) begin : g_half
            assign be_o[2*h+1:2*h] = (byte_off[LANE_AW-1:1] == (LANE_AW-1)'(h)) ? 2'b11 : 2'b00;
        end
    endgenerate

endmodule

// File: rtl/hs_store_unit.sv
module hs_store_unit
    import hs_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NPFX = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [INSTR_W-1:0]   instr,
    output logic                 instr_ready,
    output logic [REG_AW-1:0]    rf_raddr_base,
    output logic [REG_AW-1:0]    rf_raddr_src,
    input  logic [XLEN-1:0]      rf_rdata_base,
    input  logic [XLEN-1:0]      rf_rdata_src,
    output logic                 mem_we,
    output logic [XLEN-1:0]      mem_addr,
    output logic [HALF_W-1:0]    mem_wdata,
    output logic [XLEN/8-1:0]    mem_be,
    output logic                 misalign_exc
);

    localparam int DISP_W = IMM_W * NPFX;
    localparam int BE_W   = XLEN / 8;

    typedef struct packed {
        logic              busy;
        logic [XLEN-1:0]   base;
        logic [DISP_W-1:0] disp;
        logic [HALF_W-1:0] data;
    } pipe_t;

    typedef struct packed {
        logic              we;
        logic              exc;
        logic [XLEN-1:0]   addr;
        logic [HALF_W-1:0] wdata;
        logic [BE_W-1:0]   be;
    } out_t;

    pipe_t   pipe_d, pipe_q;
    out_t    out_d, out_q;
    hs_dec_t dec;
    logic    take;
    logic [DISP_W-1:0] disp;
    logic    pfx_active;

    logic              emit;
    logic [XLEN-1:0]   ea;
    logic [HALF_W-1:0] wd;
    logic [BE_W-1:0]   lane_be;
    logic              lane_odd;

    hs_decode u_dec (
        .word_i (instr),
        .dec_o  (dec)
    );

    assign instr_ready   = !pipe_q.busy;
    assign take          = instr_valid && instr_ready;
    assign rf_raddr_base = dec.base_idx;
    assign rf_raddr_src  = dec.src_idx;

    hs_prefix_acc #(.NPFX(NPFX)) u_pfx (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .is_prefix_i (dec.is_prefix),
        .imm_i       (dec.imm),
        .disp_o      (disp),
        .active_o    (pfx_active)
    );

    // Path select: the finishing extended store wins, else a plain store
    always_comb begin
        emit = 1'b0;
        ea   = '0;
        wd   = '0;
        if (pipe_q.busy) begin
            emit = 1'b1;
            ea   = pipe_q.base + XLEN'(pipe_q.disp);
            wd   = pipe_q.data;
        end else if (take && dec.is_store && !pfx_active) begin
            emit = 1'b1;
            ea   = rf_rdata_base;
            wd   = rf_rdata_src[HALF_W-1:0];
        end
    end

    hs_lane_sel #(.XLEN(XLEN)) u_lane (
        .ea_i  (ea),
        .be_o  (lane_be),
        .odd_o (lane_odd)
    );

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.busy = 1'b0;
        out_d       = out_q;
        out_d.we    = 1'b0;
        out_d.exc   = 1'b0;

        if (!pipe_q.busy && take && dec.is_store && pfx_active) begin
            pipe_d.busy = 1'b1;
            pipe_d.base = rf_rdata_base;
            pipe_d.disp = disp;
            pipe_d.data = rf_rdata_src[HALF_W-1:0];
        end

        if (emit) begin
            out_d.addr  = ea;
            out_d.wdata = wd;
            out_d.be    = lane_be;
            out_d.we    = !lane_odd;
            out_d.exc   = lane_odd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
            out_q  <= '0;
        end else begin
            pipe_q <= pipe_d;
            out_q  <= out_d;
        end
    end

    assign mem_we       = out_q.we;
    assign misalign_exc = out_q.exc;
    assign mem_addr     = out_q.addr;
    assign mem_wdata    = out_q.wdata;
    assign mem_be       = out_q.be;

endmodule

// File: rtl/hs_store_chk.sv
module hs_store_chk #(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [15:0]       instr,
    input logic              instr_ready,
    input logic              mem_we,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN/8-1:0] mem_be,
    input logic              misalign_exc
);

    localparam int BE_W = XLEN / 8;

    AST_WRITE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_addr[0]); // R9

    AST_WRITE_XOR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && misalign_exc)); // R9

    AST_LANE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 2 && mem_be[2*mem_addr[1]] && mem_be[2*mem_addr[1]+1])); // R2

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_ready |=> instr_ready); // R7

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_ready |-> (!mem_we && !misalign_exc)); // R7

    AST_NONSTORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && instr[15:8] != 8'h38) |=> (!mem_we && !misalign_exc)); // R1

    logic unused_be;
    assign unused_be = ^mem_be[BE_W-1:0];

endmodule

bind hs_store_unit hs_store_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .instr        (instr),
    .instr_ready  (instr_ready),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .misalign_exc (misalign_exc)
);

// File: tb/hs_store_unit_test.sv
module hs_store_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [15:0] instr;
    logic        instr_ready;
    logic [3:0]  rf_raddr_base, rf_raddr_src;
    logic [31:0] rf_rdata_base, rf_rdata_src;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        misalign_exc;

    logic [31:0] regs [16];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    assign rf_rdata_base = regs[rf_raddr_base];
    assign rf_rdata_src  = regs[rf_raddr_src];

    hs_store_unit uut (
        .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr (instr),
        .instr_ready (instr_ready), .rf_raddr_base (rf_raddr_base),
        .rf_raddr_src (rf_raddr_src), .rf_rdata_base (rf_rdata_base),
        .rf_rdata_src (rf_rdata_src), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_be (mem_be), .misalign_exc (misalign_exc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        instr_valid = 1'b1;
        instr       = w;
    endtask

    task automatic idle();
        instr_valid = 1'b0;
        instr       = 16'h0000;
    endtask

    function automatic logic [15:0] pfx(input logic [12:0] imm);
        return {3'b110, imm};
    endfunction

    function automatic logic [15:0] st(input logic [3:0] rb, input logic [3:0] rs);
        return {8'h38, rb, rs};
    endfunction

    // Issue a store and check its outcome against a bench-computed address
    task automatic run_store(input logic [3:0] rb, input logic [3:0] rs, input bit prefixed,
                             input logic [31:0] exp_addr, input string req);
        send(st(rb, rs));
        @(negedge clk);
        idle();
        if (prefixed) begin
            chk(instr_ready == 1'b0, {req, " R7 stall"}, 32'(instr_ready), 32'd0);
            chk(mem_we == 1'b0 && misalign_exc == 1'b0, {req, " R7 quiet"}, 32'(mem_we), 32'd0);
            @(negedge clk);
        end else begin
            chk(instr_ready == 1'b1, {req, " R3 ready"}, 32'(instr_ready), 32'd1);
        end
        chk(mem_addr == exp_addr, {req, " addr"}, mem_addr, exp_addr);
        if (exp_addr[0]) begin
            chk(misalign_exc == 1'b1 && mem_we == 1'b0, {req, " R9 trap"},
                {mem_we, misalign_exc}, 32'd1);
        end else begin
            chk(mem_we == 1'b1 && misalign_exc == 1'b0, {req, " write"}, {mem_we, misalign_exc}, 32'd2);
            chk(mem_wdata == regs[rs][15:0], {req, " R2 data"}, 32'(mem_wdata), 32'(regs[rs][15:0]));
            chk(mem_be == (exp_addr[1] ? 4'b1100 : 4'b0011), {req, " R2 lanes"},
                32'(mem_be), exp_addr[1] ? 32'hC : 32'h3);
        end
        @(negedge clk);
        chk(mem_we == 1'b0 && misalign_exc == 1'b0, {req, " one-cycle"}, {mem_we, misalign_exc}, 32'd0);
    endtask

    task automatic t_reset();
        chk(mem_we == 1'b0 && misalign_exc == 1'b0, "R10 outputs", {mem_we, misalign_exc}, 32'd0);
        chk(instr_ready == 1'b1, "R10 ready", 32'(instr_ready), 32'd1);
        run_store(4'd2, 4'd5, 1'b0, regs[2], "R10 no prefix pending");
    endtask

    task automatic t_plain();
        run_store(4'd2, 4'd5, 1'b0, regs[2], "R3 plain");
        run_store(4'd3, 4'd6, 1'b0, regs[3], "R2 upper lanes");
        run_store(4'd4, 4'd4, 1'b0, regs[4], "R1 same reg");
    endtask

    task automatic t_one_prefix();
        send(pfx(13'h1FFE));
        run_store(4'd2, 4'd5, 1'b1, regs[2] + 32'h1FFE, "R4 one prefix");
    endtask

    task automatic t_two_prefix();
        send(pfx(13'h0003));
        send(pfx(13'h0004));
        run_store(4'd2, 4'd6, 1'b1, regs[2] + ((32'h3 << 13) | 32'h4), "R5 two prefixes");
        send(pfx(13'h0001));
        send(pfx(13'h0004));
        run_store(4'd15, 4'd5, 1'b1, regs[15] + ((32'h1 << 13) | 32'h4), "R5 wrap");
    endtask

    task automatic t_three_prefix();
        send(pfx(13'h1111));
        send(pfx(13'h0002));
        send(pfx(13'h0006));
        run_store(4'd2, 4'd5, 1'b1, regs[2] + ((32'h2 << 13) | 32'h6), "R6 three prefixes");
    endtask

    task automatic t_clear();
        send(pfx(13'h0100));
        send(16'h3900);
        @(negedge clk);
        idle();
        chk(mem_we == 1'b0 && misalign_exc == 1'b0, "R1 near opcode quiet", {mem_we, misalign_exc}, 32'd0);
        run_store(4'd2, 4'd5, 1'b0, regs[2], "R8 cleared by non-store");
        send(pfx(13'h0040));
        run_store(4'd3, 4'd5, 1'b1, regs[3] + 32'h40, "R8 prefix used");
        run_store(4'd3, 4'd5, 1'b0, regs[3], "R8 cleared by store");
    endtask

    task automatic t_misalign();
        run_store(4'd7, 4'd5, 1'b0, regs[7], "R9 odd base");
        send(pfx(13'h0001));
        run_store(4'd2, 4'd5, 1'b1, regs[2] + 32'h1, "R9 odd displacement");
    endtask

    initial begin
        regs[0]  = 32'h0000_0000;
        regs[1]  = 32'h1111_1111;
        regs[2]  = 32'h0000_1000;
        regs[3]  = 32'h0000_2002;
        regs[4]  = 32'h0000_4444;
        regs[5]  = 32'hDEAD_BEEF;
        regs[6]  = 32'h1234_5678;
        regs[7]  = 32'h0000_3001;
        for (int i = 8; i < 15; i++) regs[i] = 32'h0100_0000 * i;
        regs[15] = 32'hFFFF_E000;
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        chk(mem_we == 1'b0 && misalign_exc == 1'b0 && instr_ready == 1'b1, "R10 in reset",
            {mem_we, misalign_exc, instr_ready}, 32'd1);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_one_prefix();
        t_two_prefix();
        t_three_prefix();
        t_clear();
        t_misalign();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule